// File: doc/BRIEF.md
# MDIO management frame engine

This block is a register-driven station-management master. Software places one 32-bit management word in the block. The word holds every field of a Clause-22 frame: start code, operation, PHY address, register address, turnaround code and data. If the management port is enabled, the block sends 32 preamble ones and then the word on the serial management pins, most significant bit first. For a read operation, the engine stops driving the data line at the turnaround. It then samples the sixteen bits the PHY returns and writes them back into the data field of the word, so software reads the result from the same place it wrote the command.

The management clock is the system clock divided by a ratio that a 3-bit select input chooses when each frame starts. An idle output is low for the whole of a frame, and software polls it to learn when the transfer is done. The line changes while the management clock is low. Read data is taken on the rising edge of the management clock. A PHY address with no device behind it reads as all ones, because the line is pulled up.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset, idle is 1, mdc is 0, mdio_oe is 0 and the management word reads 0.
- R2: A word write while port_en is 0 updates the word but starts no frame: idle stays 1 and mdc stays 0, even after port_en is later raised.
- R3: A frame is 32 slots of 1 followed by the 32 word bits, bit 31 first. The word layout is start[31:30], op[29:28], phy[27:23], reg[22:18], turnaround[17:16] and data[15:0].
- R4: When op = 2'b10 (read), mdio_oe is 1 for frame slots 0 to 45 and 0 for slots 46 to 63. For any other op code, mdio_oe is 1 for all 64 slots.
- R5: In a read, the line value at each MDC rising edge of slots 48 to 63 is stored into data bits 15 down to 0, in that order. Bits 31:16 of the word are left unchanged.
- R6: A read from an address that no PHY answers returns 16'hFFFF in the data field.
- R7: div_sel values 0,1,2,3,4,5 give ratios 8,16,32,48,64,96, and 6 or 7 give 96. Each slot is low for ratio/2 clock cycles and then high for ratio/2 cycles, and a frame lasts 64*ratio cycles.
- R8: idle goes low in the cycle after a write that is accepted while port_en is 1. It returns to 1 at the MDC falling edge that ends slot 63.
- R9: A word write during a frame is ignored. The frame continues unchanged and the word keeps its value.
- R10: Clearing port_en during a frame ends it in the next cycle, with idle 1, mdc 0 and mdio_oe 0.
- R11: mdio_o and mdio_oe do not change while mdc stays high.
- R12: The ratio is taken from div_sel when a frame starts. Changes to div_sel during the frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Management port enable |
| div_sel | input | 3 | MDC ratio select |
| cfg_wr | input | 1 | Write strobe for the management word |
| cfg_wdata | input | 32 | Management word to write |
| word_rd | output | 32 | Current management word, including read data |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input (pulled high externally) |

## Verification
A wrong slot counter or divider shows up in two places: the frame length, measured as the number of cycles idle is low, and the pattern of bits captured on each MDC rise. A mistake in either therefore appears as soon as the affected frame ends. A mistake in the release point or the capture index shows up in the captured output-enable pattern and in the data field read back after a read. Both cover every bit of the frame. If the abort or busy-write handling is wrong, the state is visible at the pins within one cycle of the event, or in the word read back once the frame completes.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int MW_W       = 32;
  localparam int MW_DATA_W  = 16;
  localparam int MW_OP_HI   = 29;
  localparam int MW_OP_LO   = 28;
  localparam int MW_TA_HI   = 17;
  localparam int RATIO_W    = 7;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_e;

  // Full MDC period in system clocks for a select code.
  function automatic logic [RATIO_W-1:0] mdc_ratio(input logic [2:0] sel);
    case (sel)
      3'd0:    mdc_ratio = 7'd8;
      3'd1:    mdc_ratio = 7'd16;
      3'd2:    mdc_ratio = 7'd32;
      3'd3:    mdc_ratio = 7'd48;
      3'd4:    mdc_ratio = 7'd64;
      default: mdc_ratio = 7'd96;
    endcase
  endfunction

  // Length of one MDC phase.
  function automatic logic [RATIO_W-2:0] mdc_half(input logic [2:0] sel);
    logic [RATIO_W-1:0] r;
    r = mdc_ratio(sel);
    mdc_half = r[RATIO_W-1:1];
  endfunction

  function automatic logic is_read_op(input logic [MW_W-1:0] w);
    is_read_op = (w[MW_OP_HI:MW_OP_LO] == OP_READ);
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
  import mdio_mgmt_pkg::*;
#(
  parameter int RW = RATIO_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       run,
  input  logic [2:0] div_sel,
  output logic       mdc,
  output logic       rise_ev,
  output logic       fall_ev
);
  localparam int HW = RW - 1;

  logic [HW-1:0] half_q;
  logic [HW-1:0] cnt_q;
  logic          at_half;

  assign at_half = (cnt_q == half_q - 1'b1);
  assign rise_ev = run && at_half && !mdc;
  assign fall_ev = run && at_half && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= mdc_half(3'd0);
      cnt_q  <= '0;
      mdc    <= 1'b0;
    end else if (start) begin
      half_q <= mdc_half(div_sel);
      cnt_q  <= '0;
      mdc    <= 1'b0;
    end else if (run) begin
      if (at_half) begin
        cnt_q <= '0;
        mdc   <= ~mdc;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end
  end

  // The phase length stays fixed for the whole of a frame.
  AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start) |=> $stable(half_q)); // R12

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_BITS  = 32,
  parameter int WORD_BITS = MW_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic port_en,
  input  logic fall_ev,
  output logic run,
  output logic start,
  output logic [$clog2(PRE_BITS+WORD_BITS)-1:0] slot
);
  localparam int SLOTS = PRE_BITS + WORD_BITS;
  localparam int IDX_W = $clog2(SLOTS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  eng_state_e       state_q;
  logic [IDX_W-1:0] slot_q;
  logic             last_fall;

  assign run       = (state_q == ENG_RUN);
  assign start     = cfg_wr && port_en && (state_q == ENG_IDLE);
  assign last_fall = fall_ev && (slot_q == LAST);
  assign slot      = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      slot_q  <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          if (start) begin
            state_q <= ENG_RUN;
            slot_q  <= '0;
          end
        end
        default: begin
          if (!port_en || last_fall) begin
            state_q <= ENG_IDLE;
            slot_q  <= '0;
          end else if (fall_ev) begin
            slot_q <= slot_q + 1'b1;
          end
        end
      endcase
    end
  end

  AST_SLOT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (run && port_en && !fall_ev) |=> $stable(slot_q)); // R7
  AST_LAST_FALL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && port_en && fall_ev && slot_q == LAST) |=> !run); // R8

endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_BITS  = 32,
  parameter int WORD_BITS = MW_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [WORD_BITS-1:0] cfg_wdata,
  input  logic                 run,
  input  logic [$clog2(PRE_BITS+WORD_BITS)-1:0] slot,
  input  logic                 rise_ev,
  input  logic                 mdc,
  input  logic                 mdio_i,
  output logic [WORD_BITS-1:0] word_q,
  output logic                 mdio_o,
  output logic                 mdio_oe
);
  localparam int SLOTS     = PRE_BITS + WORD_BITS;
  localparam int IDX_W     = $clog2(SLOTS);
  localparam int POS_W     = $clog2(WORD_BITS);
  localparam int REL_SLOT  = PRE_BITS + (WORD_BITS - 1 - MW_TA_HI);
  localparam int DATA_SLOT = SLOTS - MW_DATA_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  logic [IDX_W-1:0] pos_full;
  logic [POS_W-1:0] pos;
  logic             read_q;
  logic             in_pre;
  logic             cap_ev;

  assign pos_full = LAST - slot;
  assign pos      = pos_full[POS_W-1:0];
  assign read_q   = is_read_op(word_q);
  assign in_pre   = (slot < IDX_W'(PRE_BITS));
  assign cap_ev   = run && rise_ev && read_q && (slot >= IDX_W'(DATA_SLOT));

  always_comb begin
    if (!run)        mdio_o = 1'b1;
    else if (in_pre) mdio_o = 1'b1;
    else             mdio_o = word_q[pos];
  end

  assign mdio_oe = run && (!read_q || (slot < IDX_W'(REL_SLOT)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (cfg_wr && !run) begin
      word_q <= cfg_wdata;
    end else if (cap_ev) begin
      word_q[pos] <= mdio_i;
    end
  end

  AST_LINE_STILL_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R11
  AST_HEADER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(word_q[WORD_BITS-1:MW_DATA_W])); // R9
  AST_RELEASED_WHEN_SAMPLING: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |-> !mdio_oe); // R4

endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        port_en,
  input  logic [2:0]  div_sel,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] word_rd,
  output logic        idle,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int IDX_W = $clog2(PRE_BITS + MW_W);

  logic             run;
  logic             start;
  logic             run_gate;
  logic             rise_ev;
  logic             fall_ev;
  logic [IDX_W-1:0] slot;

  assign run_gate = run && port_en;
  assign idle     = !run;

  mdio_frame_seq #(.PRE_BITS(PRE_BITS), .WORD_BITS(MW_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .port_en(port_en),
    .fall_ev(fall_ev), .run(run), .start(start), .slot(slot)
  );

  mdio_mdc_gen #(.RW(RATIO_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run_gate),
    .div_sel(div_sel), .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  mdio_frame_shift #(.PRE_BITS(PRE_BITS), .WORD_BITS(MW_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .run(run), .slot(slot), .rise_ev(rise_ev), .mdc(mdc), .mdio_i(mdio_i),
    .word_q(word_rd), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!mdc && !mdio_oe)); // R1
  AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !port_en) |=> (idle && !mdc && !mdio_oe)); // R10

endmodule

// File: tb/mdio_mgmt_engine_bench.sv
module mdio_mgmt_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        port_en;
  logic [2:0]  div_sel;
  logic        cfg_wr;
  logic [31:0] cfg_wdata;
  logic [31:0] word_rd;
  logic        idle, mdc, mdio_o, mdio_oe, mdio_i;

  logic        phy_en = 1'b0;
  logic        phy_bit = 1'b1;
  int          rise_cnt = 0;
  logic [63:0] cap = '0;
  logic [63:0] oecap = '0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          ended = 0;
  int          hi_moves = 0;

  localparam logic [4:0] PHY_HERE = 5'd3;

  always #2.5 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_mgmt_engine u_mdio_mgmt_engine (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .div_sel(div_sel),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .word_rd(word_rd), .idle(idle),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  function automatic int exp_ratio(input int sel);
    if (sel <= 2) return 8 << sel;
    if (sel == 3) return 48;
    if (sel == 4) return 64;
    return 96;
  endfunction

  function automatic logic [15:0] phy_val(input logic [4:0] r);
    return {3'b101, r, ~r, 3'b001};
  endfunction

  function automatic logic [31:0] mk_word(input logic [1:0] op, input logic [4:0] pa,
                                          input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, op, pa, ra, 2'b10, d};
  endfunction

  // Line observer: one bit per MDC rise
  always @(posedge mdc) begin
    if (rise_cnt < 64) begin
      cap[63-rise_cnt]   = mdio_i;
      oecap[63-rise_cnt] = mdio_oe;
      rise_cnt++;
    end
  end

  // PHY model answering reads at one address
  always @(negedge mdc) begin
    if (rise_cnt >= 48 && rise_cnt < 64 && cap[29:28] == 2'b10 && cap[27:23] == PHY_HERE) begin
      logic [15:0] pv;
      pv = phy_val(cap[22:18]);
      phy_en  = 1'b1;
      phy_bit = pv[15-(rise_cnt-48)];
    end else begin
      phy_en = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // kind 0: none, 1: busy write, 2: div_sel change
  task automatic do_frame(input logic [31:0] w, input logic [2:0] sel, input int kind,
                          input int at, output int dur, output int hi);
    logic pm, po, poe;
    @(negedge clk);
    rise_cnt = 0; cap = '0; oecap = '0; hi_moves = 0;
    div_sel = sel; cfg_wdata = w; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    dur = 0; hi = 0; pm = 1'b0; po = mdio_o; poe = mdio_oe;
    while (idle == 1'b0 && dur < 20000) begin
      if (mdc && pm && (mdio_o != po || mdio_oe != poe)) hi_moves++;
      pm = mdc; po = mdio_o; poe = mdio_oe;
      dur++;
      if (mdc) hi++;
      cfg_wr = 1'b0;
      if (kind == 1 && dur == at) begin cfg_wr = 1'b1; cfg_wdata = 32'hFFFF_FFFF; end
      if (kind == 2 && dur == at) div_sel = 3'd5;
      @(negedge clk);
    end
    cfg_wr = 1'b0;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    wrap_up();
  end

  initial begin
    int dur, hi;
    logic [31:0] w;
    rst_n = 1'b0; port_en = 1'b0; div_sel = 3'd0; cfg_wr = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle == 1'b1,   "R1 idle",  64'(idle), 64'd1);
    chk(mdc == 1'b0,    "R1 mdc",   64'(mdc), 64'd0);
    chk(mdio_oe == 1'b0,"R1 oe",    64'(mdio_oe), 64'd0);
    chk(word_rd == '0,  "R1 word",  64'(word_rd), 64'd0);

    // R2: write with port disabled
    w = mk_word(2'b01, 5'd2, 5'd4, 16'h1234);
    cfg_wdata = w; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    begin
      int moved = 0;
      for (int i = 0; i < 20; i++) begin
        if (i == 10) port_en = 1'b1;
        if (!idle || mdc) moved++;
        @(negedge clk);
      end
      chk(moved == 0, "R2 no frame", 64'(moved), 64'd0);
    end
    chk(word_rd == w, "R2 word stored", 64'(word_rd), 64'(w));

    // Write frames across all ratio selects
    for (int s = 0; s < 8; s++) begin
      w = mk_word(2'b01, PHY_HERE, 5'(s), 16'hA5C3 ^ 16'(s * 16'h0111));
      do_frame(w, 3'(s), 0, 0, dur, hi);
      chk(dur == 64 * exp_ratio(s), "R7 frame length", 64'(dur), 64'(64 * exp_ratio(s)));
      chk(hi == 32 * exp_ratio(s), "R7 high time", 64'(hi), 64'(32 * exp_ratio(s)));
      chk(cap == {32'hFFFF_FFFF, w}, "R3 frame bits", cap, {32'hFFFF_FFFF, w});
      chk(oecap == '1, "R4 write drives all", oecap, '1);
      chk(word_rd == w, "R8 word after write", 64'(word_rd), 64'(w));
      chk(hi_moves == 0, "R11 line still in high", 64'(hi_moves), 64'd0);
      chk(idle && !mdc && !mdio_oe, "R8 idle after frame", 64'({idle, mdc, mdio_oe}), 64'b100);
    end

    // Reads from the present PHY
    for (int k = 0; k < 3; k++) begin
      logic [4:0] ra;
      logic [2:0] sel;
      ra  = (k == 0) ? 5'd7 : (k == 1) ? 5'h1E : 5'h00;
      sel = (k == 0) ? 3'd0 : (k == 1) ? 3'd3 : 3'd1;
      w = mk_word(2'b10, PHY_HERE, ra, 16'h0000);
      do_frame(w, sel, 0, 0, dur, hi);
      chk(oecap == 64'hFFFF_FFFF_FFFC_0000, "R4 read release", oecap, 64'hFFFF_FFFF_FFFC_0000);
      chk(cap[63:18] == {32'hFFFF_FFFF, w[31:18]}, "R3 read header", 64'(cap[63:18]),
          64'({32'hFFFF_FFFF, w[31:18]}));
      chk(word_rd == {w[31:16], phy_val(ra)}, "R5 read data", 64'(word_rd),
          64'({w[31:16], phy_val(ra)}));
      chk(dur == 64 * exp_ratio(sel), "R7 read length", 64'(dur), 64'(64 * exp_ratio(sel)));
    end

    // R6: absent PHY addresses
    w = mk_word(2'b10, 5'd9, 5'd2, 16'h0F0F);
    do_frame(w, 3'd1, 0, 0, dur, hi);
    chk(word_rd == {w[31:16], 16'hFFFF}, "R6 absent phy", 64'(word_rd), 64'({w[31:16], 16'hFFFF}));
    w = mk_word(2'b10, 5'd31, 5'd31, 16'h0000);
    do_frame(w, 3'd7, 0, 0, dur, hi);
    chk(word_rd == {w[31:16], 16'hFFFF}, "R6 absent phy 31", 64'(word_rd), 64'({w[31:16], 16'hFFFF}));

    // R9: busy write ignored
    w = mk_word(2'b10, PHY_HERE, 5'd5, 16'h0000);
    do_frame(w, 3'd0, 1, 100, dur, hi);
    chk(word_rd == {w[31:16], phy_val(5'd5)}, "R9 busy write ignored", 64'(word_rd),
        64'({w[31:16], phy_val(5'd5)}));
    chk(dur == 512, "R9 frame unchanged", 64'(dur), 64'd512);

    // R12: ratio latched at frame start
    w = mk_word(2'b01, PHY_HERE, 5'd1, 16'hBEEF);
    do_frame(w, 3'd0, 2, 50, dur, hi);
    chk(dur == 512, "R12 ratio latched", 64'(dur), 64'd512);
    chk(cap == {32'hFFFF_FFFF, w}, "R12 bits intact", cap, {32'hFFFF_FFFF, w});

    // R10: abort by clearing enable
    @(negedge clk);
    div_sel = 3'd0; cfg_wdata = mk_word(2'b01, PHY_HERE, 5'd3, 16'h5555); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    repeat (150) @(negedge clk);
    chk(idle == 1'b0, "R10 running before abort", 64'(idle), 64'd0);
    port_en = 1'b0;
    @(negedge clk);
    chk(idle && !mdc && !mdio_oe, "R10 abort", 64'({idle, mdc, mdio_oe}), 64'b100);
    port_en = 1'b1;

    // Recovery frame after abort
    w = mk_word(2'b10, PHY_HERE, 5'd12, 16'h0000);
    do_frame(w, 3'd2, 0, 0, dur, hi);
    chk(word_rd == {w[31:16], phy_val(5'd12)}, "R10 recovery read", 64'(word_rd),
        64'({w[31:16], phy_val(5'd12)}));

    wrap_up();
  end

endmodule